// File: doc/BRIEF.md
# Hierarchical Interrupt Status Aggregator

This block gathers a large number of peripheral interrupt lines into a single interrupt output. The lines are grouped eight to a block and blocks eight to a master. A summary tree over those groups lets software find a pending source in a few byte reads: first the root register, then one master register, then one block. Every line has its own trigger setting (rising edge, falling edge, both edges, active-high level or active-low level), a full mask, and a clear. Each line is synchronized with two flops before it is detected.

Per-line status and configuration are reached indirectly. Software writes a block number into a select register. After that, one address returns the latched flags of the selected block, another returns the raw synchronized input levels of that block, and a third accepts a configuration byte. The 3-bit field in that byte names one of the block's eight lines. Register accesses use a plain byte-wide port with address, write strobe, write data and a combinational read path.

Top module: `irq_agg`

## Requirements
- R1: After reset every line is in edge mode with both edge masks set, the block-select register is 0, the root register reads 0 and irq_o is low. An edge on an unconfigured line latches nothing.
- R2: The configuration byte at address 2 has these fields: bit 7 write-enable, bit 6 level-select, bits 5:3 line index within the selected block, bit 2 mask-falling, bit 1 mask-rising, bit 0 clear. A byte written with bit 7 at 0 changes nothing.
- R3: In edge mode (bit 6 = 0), a line latches on a rising edge when mask-rising is 0 and on a falling edge when mask-falling is 0. Both edges can be enabled together. The latched flag appears on the third rising clock edge after the input changes.
- R4: In level mode (bit 6 = 1), mask-rising = 0 latches while the input is high and mask-falling = 0 latches while the input is low. With both masks set, the line never latches.
- R5: A configuration write with the clear bit set clears that line's latched flag. A level line whose input is still active stays latched after the clear.
- R6: Address 1 holds the block select. Address 3 returns the eight latched flags of the selected block, with line n at bit n%8 of block n/8. A selected block number beyond the last block reads 0 and ignores configuration writes.
- R7: Address 4 returns the synchronized raw levels of the selected block's lines. These levels do not depend on mask or latch state.
- R8: The master register for master m sits at address 8+m. Its bit b%8 is set when block b holds a latched line that is not fully masked. Root register bit m+1 (address 0) is the OR of master m, root bit 0 always reads 0, and irq_o is high when any master bit is set.
- R9: Masking a latched line (setting both mask bits without clear) removes it from the master and root summaries, but its triggered-status bit stays set.
- R10: When a clear write and a newly detected trigger on the same line fall in the same clock cycle, the line stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_IRQS | Peripheral interrupt lines, asynchronous |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from addr_i |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
Two operations can land on the same line in the same cycle: the clear carried by a configuration write, and a newly detected trigger. The bench raises a rising-enabled input and waits exactly two clock edges, so the synchronized edge is visible in the cycle when the clear write commits. It then expects the triggered-status bit to read 1. A second clear with no new edge must read 0, which shows that the first result came from the coincident trigger and not from a clear that failed to act.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef struct packed {
    logic       wen;
    logic       lvl;
    logic [2:0] idx;
    logic       mask_f;
    logic       mask_r;
    logic       clr;
  } cfg_byte_t;

  localparam int A_ROOT  = 0;
  localparam int A_BSEL  = 1;
  localparam int A_CFG   = 2;
  localparam int A_TRIG  = 3;
  localparam int A_RAW   = 4;
  localparam int A_MBASE = 8;
endpackage

// File: rtl/irq_agg_cell.sv
module irq_agg_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic cfg_we_i,
  input  logic cfg_lvl_i,
  input  logic cfg_mr_i,
  input  logic cfg_mf_i,
  input  logic cfg_clr_i,
  output logic raw_o,
  output logic lat_o,
  output logic msk_o
);
  logic [2:0] sh_q;
  logic       lvl_q, mr_q, mf_q, lat_q;
  logic       lvl_e, mr_e, mf_e, rise, fall, hit;

  // new config takes effect in the write cycle
  assign lvl_e = cfg_we_i ? cfg_lvl_i : lvl_q;
  assign mr_e  = cfg_we_i ? cfg_mr_i  : mr_q;
  assign mf_e  = cfg_we_i ? cfg_mf_i  : mf_q;
  assign rise  = sh_q[1] & ~sh_q[2];
  assign fall  = ~sh_q[1] & sh_q[2];
  assign hit   = lvl_e ? ((~mr_e & sh_q[1]) | (~mf_e & ~sh_q[1]))
                       : ((~mr_e & rise) | (~mf_e & fall));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      lvl_q <= 1'b0;
      mr_q  <= 1'b1;
      mf_q  <= 1'b1;
      lat_q <= 1'b0;
    end else begin
      sh_q <= {sh_q[1:0], irq_i};
      if (cfg_we_i) begin
        lvl_q <= cfg_lvl_i;
        mr_q  <= cfg_mr_i;
        mf_q  <= cfg_mf_i;
      end
      // detection wins over clear
      lat_q <= hit | (lat_q & ~(cfg_we_i & cfg_clr_i));
    end
  end

  assign raw_o = sh_q[1];
  assign lat_o = lat_q;
  assign msk_o = mr_q & mf_q;
endmodule

// File: rtl/irq_agg_tree.sv
module irq_agg_tree #(
  parameter int NUM_BLKS = 10,
  parameter int NUM_MSTR = 2
) (
  input  logic [NUM_BLKS*8-1:0] lat_i,
  input  logic [NUM_BLKS*8-1:0] msk_i,
  output logic [NUM_MSTR*8-1:0] mstr_o
);
  localparam int BPAD = NUM_MSTR * 8;
  logic [BPAD-1:0] blk_pend;

  for (genvar b = 0; b < BPAD; b++) begin : g_blk
    if (b < NUM_BLKS) begin : g_real
      assign blk_pend[b] = |(lat_i[b*8 +: 8] & ~msk_i[b*8 +: 8]);
    end else begin : g_pad
      assign blk_pend[b] = 1'b0;
    end
  end

  assign mstr_o = blk_pend;
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_IRQS = 80,
  parameter int ADDR_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_IRQS-1:0] irq_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  output logic                irq_o
);
  localparam int NUM_BLKS = (NUM_IRQS + 7) / 8;
  localparam int NUM_MSTR = (NUM_BLKS + 7) / 8;
  localparam int PAD      = NUM_BLKS * 8;
  localparam logic [7:0] NUM_BLKS_B = 8'(NUM_BLKS);

  logic [7:0]          blk_sel_q;
  cfg_byte_t           cfg_w;
  logic                cfg_go;
  logic [PAD-1:0]      lat_pad, raw_pad, msk_pad;
  logic [NUM_MSTR*8-1:0] mstr;
  logic [NUM_MSTR-1:0] mstr_any;
  logic [7:0]          root, trig_sel, raw_sel;

  assign cfg_w  = cfg_byte_t'(wdata_i);
  assign cfg_go = we_i && (addr_i == ADDR_W'(A_CFG)) && cfg_w.wen && (blk_sel_q < NUM_BLKS_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              blk_sel_q <= '0;
    else if (we_i && addr_i == ADDR_W'(A_BSEL)) blk_sel_q <= wdata_i;
  end

  for (genvar g = 0; g < PAD; g++) begin : g_line
    if (g < NUM_IRQS) begin : g_cell
      logic sel;
      assign sel = cfg_go && (blk_sel_q == 8'(g / 8)) && (cfg_w.idx == 3'(g % 8));
      irq_agg_cell u_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .irq_i    (irq_i[g]),
        .cfg_we_i (sel),
        .cfg_lvl_i(cfg_w.lvl),
        .cfg_mr_i (cfg_w.mask_r),
        .cfg_mf_i (cfg_w.mask_f),
        .cfg_clr_i(cfg_w.clr),
        .raw_o    (raw_pad[g]),
        .lat_o    (lat_pad[g]),
        .msk_o    (msk_pad[g])
      );
    end else begin : g_pad
      assign raw_pad[g] = 1'b0;
      assign lat_pad[g] = 1'b0;
      assign msk_pad[g] = 1'b1;
    end
  end

  irq_agg_tree #(.NUM_BLKS(NUM_BLKS), .NUM_MSTR(NUM_MSTR)) u_tree (
    .lat_i (lat_pad),
    .msk_i (msk_pad),
    .mstr_o(mstr)
  );

  for (genvar m = 0; m < NUM_MSTR; m++) begin : g_mstr
    assign mstr_any[m] = |mstr[m*8 +: 8];
  end

  always_comb begin
    root = '0;
    for (int m = 0; m < NUM_MSTR; m++) root[m+1] = mstr_any[m];
  end

  always_comb begin
    trig_sel = '0;
    raw_sel  = '0;
    for (int b = 0; b < NUM_BLKS; b++) begin
      if (blk_sel_q == 8'(b)) begin
        trig_sel = lat_pad[b*8 +: 8];
        raw_sel  = raw_pad[b*8 +: 8];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if      (addr_i == ADDR_W'(A_ROOT)) rdata_o = root;
    else if (addr_i == ADDR_W'(A_BSEL)) rdata_o = blk_sel_q;
    else if (addr_i == ADDR_W'(A_TRIG)) rdata_o = trig_sel;
    else if (addr_i == ADDR_W'(A_RAW))  rdata_o = raw_sel;
    else begin
      for (int m = 0; m < NUM_MSTR; m++)
        if (addr_i == ADDR_W'(A_MBASE + m)) rdata_o = mstr[m*8 +: 8];
    end
  end

  assign irq_o = |mstr_any;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NUM_IRQS = 80,
  parameter int ADDR_W   = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           we_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [7:0]                     wdata_i,
  input logic [7:0]                     rdata_o,
  input logic                           irq_o,
  input logic [7:0]                     blk_sel_i,
  input logic [((NUM_IRQS+7)/8)*8-1:0]  lat_i,
  input logic [((NUM_IRQS+7)/8)*8-1:0]  msk_i
);
  localparam int NUM_BLKS = (NUM_IRQS + 7) / 8;
  localparam int PAD      = NUM_BLKS * 8;
  localparam int TW       = $clog2(PAD);

  logic [TW-1:0] tgt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgt_q <= '0;
    else         tgt_q <= TW'({blk_sel_i, wdata_i[5:3]});
  end

  // R2
  no_wen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(A_CFG) && !wdata_i[7]) |=> $stable(msk_i));

  // R5
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(A_CFG) && wdata_i[7:6] == 2'b11 && wdata_i[2:0] == 3'b111
     && blk_sel_i < 8'(NUM_BLKS)) |=> !lat_i[tgt_q]);

  // R4
  masked_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_i & ~$past(lat_i) & msk_i) == '0);

  // R8
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !we_i) |=> irq_o);

  // R8
  root_bit0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(A_ROOT)) |-> !rdata_o[0]);
endmodule

bind irq_agg irq_agg_chk #(.NUM_IRQS(NUM_IRQS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .blk_sel_i(blk_sel_q),
  .lat_i    (lat_pad),
  .msk_i    (msk_pad)
);

// File: tb/irq_agg_test.sv
`timescale 1ns/1ps
module irq_agg_test;
  localparam int NI = 80;
  localparam logic [3:0] AR = 4'd0, AB = 4'd1, AC = 4'd2, AT = 4'd3, AW = 4'd4, AM = 4'd8;

  logic          clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [NI-1:0] irq = '0;
  logic [3:0]    addr = '0;
  logic [7:0]    wdata = '0, rdata, d;
  logic          irq_o;
  int            checks = 0, errors = 0;

  always #4 clk = ~clk;

  irq_agg #(.NUM_IRQS(NI), .ADDR_W(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_o));

  // {lvl, mask_r, mask_f, start, end, expected}
  localparam logic [5:0] VEC [12] = '{
    6'b0_01_01_1, 6'b0_01_10_0, 6'b0_10_10_1, 6'b0_10_01_0,
    6'b0_00_01_1, 6'b0_00_10_1, 6'b1_01_01_1, 6'b1_01_00_0,
    6'b1_10_10_1, 6'b1_10_11_0, 6'b1_11_01_0, 6'b0_11_01_0};

  function automatic logic [7:0] cfgb(logic lvl, int idx, logic mf, logic mr, logic clr);
    return {1'b1, lvl, 3'(idx), mf, mr, clr};
  endfunction

  task automatic wr(logic [3:0] a, logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(AR, d); chk("R1 root", d, 8'h00);
    chk("R1 irq_o", {7'd0, irq_o}, 8'h00);
    rd(AB, d); chk("R1 bsel", d, 8'h00);
    @(negedge clk) irq[5] = 1'b1;
    settle();
    rd(AT, d); chk("R1 unconfigured edge", d, 8'h00);
    // R7 raw level visible while masked
    rd(AW, d); chk("R7 raw", d, 8'h20);

    // R3 R4 table
    for (int i = 0; i < 12; i++) begin
      int idx = 3 + 6 * i;
      logic [5:0] v = VEC[i];
      wr(AB, 8'(idx / 8));
      wr(AC, cfgb(1'b0, idx % 8, 1'b1, 1'b1, 1'b1));
      @(negedge clk) irq[idx] = v[2];
      settle();
      wr(AC, cfgb(v[5], idx % 8, v[3], v[4], 1'b1));
      @(negedge clk) irq[idx] = v[1];
      settle();
      rd(AT, d);
      chk(v[5] ? "R4 level vector" : "R3 edge vector", {7'd0, d[idx % 8]}, {7'd0, v[0]});
    end

    // fresh start for hierarchy tests
    @(negedge clk) rst_n = 1'b0; irq = '0;
    @(negedge clk) rst_n = 1'b1;
    settle();

    // R2 write without write-enable ignored
    wr(AB, 8'd0);
    wr(AC, cfgb(1'b0, 6, 1'b1, 1'b0, 1'b0) & 8'h7F);
    @(negedge clk) irq[6] = 1'b1;
    settle();
    rd(AT, d); chk("R2 no wen", d, 8'h00);
    @(negedge clk) irq[6] = 1'b0;
    settle();
    wr(AC, cfgb(1'b0, 6, 1'b1, 1'b0, 1'b0));
    @(negedge clk) irq[6] = 1'b1;
    settle();
    rd(AT, d); chk("R3 rising after enable", d, 8'h40);

    // R8 hierarchy: line 70 = block 8 bit 6, master 1 bit 0
    wr(AB, 8'd8);
    wr(AC, cfgb(1'b0, 6, 1'b1, 1'b0, 1'b1));
    @(negedge clk) irq[70] = 1'b1;
    settle();
    rd(AT, d); chk("R6 trig blk8", d, 8'h40);
    rd(AR, d); chk("R8 root", d, 8'h06);
    rd(AM, d); chk("R8 master0", d, 8'h01);
    rd(AM + 4'd1, d); chk("R8 master1", d, 8'h01);
    chk("R8 irq_o", {7'd0, irq_o}, 8'h01);

    // R9 mask hides summary, keeps status
    wr(AC, cfgb(1'b0, 6, 1'b1, 1'b1, 1'b0));
    rd(AT, d); chk("R9 trig kept", d, 8'h40);
    rd(AM + 4'd1, d); chk("R9 master1", d, 8'h00);
    rd(AR, d); chk("R9 root", d, 8'h02);

    // R6 out-of-range block
    wr(AB, 8'd12);
    rd(AT, d); chk("R6 out of range", d, 8'h00);

    // R5 clear
    wr(AB, 8'd0);
    wr(AC, cfgb(1'b0, 6, 1'b1, 1'b0, 1'b1));
    rd(AT, d); chk("R5 clear", d, 8'h00);
    chk("R5 irq_o low", {7'd0, irq_o}, 8'h00);
    @(negedge clk) irq[7] = 1'b1;
    wr(AC, cfgb(1'b1, 7, 1'b1, 1'b0, 1'b1));
    settle();
    wr(AC, cfgb(1'b1, 7, 1'b1, 1'b0, 1'b1));
    rd(AT, d); chk("R5 level stays", d, 8'h80);
    @(negedge clk) irq[7] = 1'b0;
    settle();
    wr(AC, cfgb(1'b1, 7, 1'b1, 1'b0, 1'b1));
    rd(AT, d); chk("R5 level cleared", d, 8'h00);

    // R10 clear coincident with new edge
    @(negedge clk) irq[6] = 1'b0;
    settle();
    @(negedge clk) irq[6] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(AC, cfgb(1'b0, 6, 1'b1, 1'b0, 1'b1));
    rd(AT, d); chk("R10 event wins", d, 8'h40);
    wr(AC, cfgb(1'b0, 6, 1'b1, 1'b0, 1'b1));
    rd(AT, d); chk("R10 plain clear", d, 8'h00);

    finish_run();
  end
endmodule